// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block decides, for each memory address seen at a bus bridge, whether the transaction crosses the bridge. It holds two programmable memory windows. Each window is a pair of 32-bit registers, a base and a limit, that are aligned to 4 KB pages. Each window also has a prefetchable attribute, taken from one bit of the bridge-control word. A configuration port writes and reads these registers with byte enables. Reads return data combinationally.

The caller presents an address and a direction flag. The direction flag says whether the address comes from the primary side or the secondary side. One clock later the block returns a registered result: a hit flag for each window, the forward decision, and the prefetchable attribute of the window that claimed the access. A primary-side address crosses the bridge when a window claims it. A secondary-side address crosses when no window claims it. A window whose base and limit are both zero is disabled, so after reset nothing is claimed.

Top module: `bmwd_top`

## Requirements
- R1: While reset is asserted and after it, all writable register bits are 0 and win_hit_o, fwd_o and fwd_pref_o are 0. A base reads 0x00000000, a limit reads 0x00000FFF, and the control word reads 0.
- R2: The base of window 0 is at byte offset 0x1C and the base of window 1 is at 0x24. Bits 31:12 are read/write. Bits 11:0 always read 0, and writes to them are ignored.
- R3: The limit of window 0 is at offset 0x20 and the limit of window 1 is at 0x28. Bits 31:12 are read/write. Bits 11:0 always read 0xFFF.
- R4: cfg_be_i[k] gates the write of data bits 8k+7:8k. A write whose enabled bytes touch no stored bit changes nothing.
- R5: The control word is at offset 0x3C. Bit 24 is the prefetchable flag of window 0 and bit 25 is the prefetchable flag of window 1. Its other bits read 0. win_pref_o shows both flags directly.
- R6: A window is enabled only while bits 31:12 of its base or bits 31:12 of its limit are nonzero.
- R7: Window i hits when it is enabled and base[31:12] <= addr[31:12] <= limit[31:12]. When base is above limit, the window hits nothing.
- R8: win_hit_o, fwd_o and fwd_pref_o reflect the address and direction sampled at the previous rising clock edge.
- R9: With txn_from_sec_i = 0 (primary side), fwd_o = 1 when any window hits. With txn_from_sec_i = 1 (secondary side), fwd_o = 1 when no window hits.
- R10: For a primary-side access, fwd_pref_o is the prefetchable flag of the lowest-numbered window that hits, and window 0 wins when both windows hit. fwd_pref_o is 0 on a miss and on secondary-side accesses.
- R11: Reads of any other dword offset return 0, and writes to such offsets are ignored. cfg_addr_i[1:0] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, combinational |
| txn_addr_i | input | 32 | Transaction address |
| txn_from_sec_i | input | 1 | 1: address comes from the secondary side |
| win_hit_o | output | 2 | Registered hit flag for each window |
| win_pref_o | output | 2 | Prefetchable flag for each window |
| fwd_o | output | 1 | Registered forward decision |
| fwd_pref_o | output | 1 | Prefetchable attribute of the claiming window |

## Verification
The assertions check on every cycle the following:
- the direction rule that links fwd_o to the hit flags;
- that the prefetch result never appears without a primary-side hit;
- the constant low bits of base and limit reads;
- the quiet outputs during reset.

Only the bench's scenarios can show the following:
- the page comparison against programmed bounds, including both inclusive edges and an inverted window;
- enabling a window through the limit alone;
- the byte-enable merge;
- the priority between overlapping windows.

// File: rtl/bmwd_pkg.sv
package bmwd_pkg;
  localparam int CFG_AW  = 8;
  localparam int CFG_DW  = 32;
  localparam int CFG_BW  = CFG_DW / 8;
  localparam logic [CFG_AW-1:0] WIN_BASE_OFS0  = 8'h1C;
  localparam logic [CFG_AW-1:0] WIN_LIMIT_OFS0 = 8'h20;
  localparam int                WIN_STRIDE     = 8;
  localparam logic [CFG_AW-1:0] CTL_OFS        = 8'h3C;
  localparam int                PREF_LSB       = 24;

  function automatic logic [CFG_DW-1:0] be_merge(
    input logic [CFG_DW-1:0] old_v,
    input logic [CFG_DW-1:0] new_v,
    input logic [CFG_BW-1:0] be
  );
    logic [CFG_DW-1:0] r;
    r = old_v;
    for (int k = 0; k < CFG_BW; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/bmwd_win_regs.sv
module bmwd_win_regs
  import bmwd_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                PAGE_W    = 12,
  parameter logic [CFG_AW-1:0] BASE_OFS  = 8'h1C,
  parameter logic [CFG_AW-1:0] LIMIT_OFS = 8'h20,
  localparam int               PN        = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_BW-1:0] cfg_be_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic [CFG_DW-1:0] rd_data_o,
  output logic [PN-1:0]     base_o,
  output logic [PN-1:0]     limit_o,
  output logic              en_o
);
  logic [PN-1:0] base_q, limit_q;
  logic          sel_base, sel_limit;
  logic [CFG_DW-1:0] base_full, limit_full, base_new, limit_new;

  assign sel_base  = cfg_addr_i[CFG_AW-1:2] == BASE_OFS[CFG_AW-1:2];
  assign sel_limit = cfg_addr_i[CFG_AW-1:2] == LIMIT_OFS[CFG_AW-1:2];

  assign base_full  = {base_q, {PAGE_W{1'b0}}};
  assign limit_full = {limit_q, {PAGE_W{1'b1}}};
  assign base_new   = be_merge(base_full, cfg_wdata_i, cfg_be_i);
  assign limit_new  = be_merge(limit_full, cfg_wdata_i, cfg_be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (cfg_we_i) begin
      if (sel_base)  base_q  <= base_new[ADDR_W-1:PAGE_W];
      if (sel_limit) limit_q <= limit_new[ADDR_W-1:PAGE_W];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (sel_base)       rd_data_o = base_full;
    else if (sel_limit) rd_data_o = limit_full;
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
  assign en_o    = (|base_q) || (|limit_q);
endmodule

// File: rtl/bmwd_ctl_reg.sv
module bmwd_ctl_reg
  import bmwd_pkg::*;
#(
  parameter int                NUM_WIN = 2,
  parameter logic [CFG_AW-1:0] OFS     = 8'h3C,
  parameter int                LSB     = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_BW-1:0]  cfg_be_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  output logic [CFG_DW-1:0]  rd_data_o,
  output logic [NUM_WIN-1:0] pref_o
);
  logic [NUM_WIN-1:0] pref_q;
  logic [CFG_DW-1:0]  cur_full, new_full;
  logic               sel;

  assign sel = cfg_addr_i[CFG_AW-1:2] == OFS[CFG_AW-1:2];

  always_comb begin
    cur_full = '0;
    cur_full[LSB +: NUM_WIN] = pref_q;
  end
  assign new_full = be_merge(cur_full, cfg_wdata_i, cfg_be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pref_q <= '0;
    else if (cfg_we_i && sel) pref_q <= new_full[LSB +: NUM_WIN];
  end

  assign rd_data_o = sel ? cur_full : '0;
  assign pref_o    = pref_q;
endmodule

// File: rtl/bmwd_win_match.sv
module bmwd_win_match #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  localparam int PN    = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PN-1:0]     base_i,
  input  logic [PN-1:0]     limit_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [PN-1:0] page;
  assign page  = addr_i[ADDR_W-1:PAGE_W];
  assign hit_o = en_i && (page >= base_i) && (page <= limit_i);
endmodule

// File: rtl/bmwd_top.sv
module bmwd_top
  import bmwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 12,
  parameter int NUM_WIN = 2,
  localparam int PN     = ADDR_W - PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_BW-1:0]  cfg_be_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  output logic [CFG_DW-1:0]  cfg_rdata_o,
  input  logic [ADDR_W-1:0]  txn_addr_i,
  input  logic               txn_from_sec_i,
  output logic [NUM_WIN-1:0] win_hit_o,
  output logic [NUM_WIN-1:0] win_pref_o,
  output logic               fwd_o,
  output logic               fwd_pref_o
);
  logic [CFG_DW-1:0]  win_rd [NUM_WIN];
  logic [CFG_DW-1:0]  ctl_rd;
  logic [NUM_WIN-1:0] hit_d, pref;
  logic               fwd_d, fwd_pref_d, sel_pref;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [PN-1:0] base, limit;
    logic          en;
    bmwd_win_regs #(
      .ADDR_W   (ADDR_W),
      .PAGE_W   (PAGE_W),
      .BASE_OFS (CFG_AW'(WIN_BASE_OFS0 + WIN_STRIDE * i)),
      .LIMIT_OFS(CFG_AW'(WIN_LIMIT_OFS0 + WIN_STRIDE * i))
    ) u_regs (
      .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_be_i, .cfg_wdata_i,
      .rd_data_o(win_rd[i]),
      .base_o   (base),
      .limit_o  (limit),
      .en_o     (en)
    );
    bmwd_win_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_match (
      .addr_i (txn_addr_i),
      .base_i (base),
      .limit_i(limit),
      .en_i   (en),
      .hit_o  (hit_d[i])
    );
  end

  bmwd_ctl_reg #(.NUM_WIN(NUM_WIN), .OFS(CTL_OFS), .LSB(PREF_LSB)) u_ctl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_be_i, .cfg_wdata_i,
    .rd_data_o(ctl_rd),
    .pref_o   (pref)
  );

  always_comb begin
    cfg_rdata_o = ctl_rd;
    for (int i = 0; i < NUM_WIN; i++) cfg_rdata_o |= win_rd[i];
  end

  // lowest-numbered hitting window supplies the attribute
  always_comb begin
    sel_pref = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (hit_d[i]) sel_pref = pref[i];
  end

  assign fwd_d      = txn_from_sec_i ? ~(|hit_d) : (|hit_d);
  assign fwd_pref_d = ~txn_from_sec_i & sel_pref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_hit_o  <= '0;
      fwd_o      <= 1'b0;
      fwd_pref_o <= 1'b0;
    end else begin
      win_hit_o  <= hit_d;
      fwd_o      <= fwd_d;
      fwd_pref_o <= fwd_pref_d;
    end
  end

  assign win_pref_o = pref;
endmodule

// File: rtl/bmwd_chk.sv
module bmwd_chk
  import bmwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CFG_AW-1:0]  cfg_addr_i,
  input logic [CFG_DW-1:0]  cfg_rdata_o,
  input logic               txn_from_sec_i,
  input logic [NUM_WIN-1:0] win_hit_o,
  input logic               fwd_o,
  input logic               fwd_pref_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_FWD_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    fwd_o == ($past(txn_from_sec_i) ? !(|win_hit_o) : (|win_hit_o))); // R9

  AST_SEC_NO_PREF: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(txn_from_sec_i) |-> !fwd_pref_o); // R10

  AST_PREF_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_pref_o |-> ((|win_hit_o) && fwd_o)); // R10

  AST_BASE_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i[CFG_AW-1:2] == 6'h07 || cfg_addr_i[CFG_AW-1:2] == 6'h09)
      |-> cfg_rdata_o[11:0] == 12'h000); // R2

  AST_LIMIT_LOW_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i[CFG_AW-1:2] == 6'h08 || cfg_addr_i[CFG_AW-1:2] == 6'h0A)
      |-> cfg_rdata_o[11:0] == 12'hFFF); // R3

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (win_hit_o == '0 && !fwd_o && !fwd_pref_o)); // R1
endmodule

bind bmwd_top bmwd_chk #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_chk (
  .clk_i, .rst_ni, .cfg_addr_i, .cfg_rdata_o, .txn_from_sec_i,
  .win_hit_o, .fwd_o, .fwd_pref_o
);

// File: tb/tb_bmwd_top.sv
module tb_bmwd_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {from_sec, addr[31:0], exp_hit[1:0], exp_fwd, exp_pref}
  localparam logic [36:0] VECS [NVEC] = '{
    {1'b0, 32'h0FFF_FFFF, 2'b00, 1'b0, 1'b0},
    {1'b0, 32'h1000_0000, 2'b01, 1'b1, 1'b0},
    {1'b0, 32'h1000_3FFF, 2'b01, 1'b1, 1'b0},
    {1'b0, 32'h1000_4000, 2'b00, 1'b0, 1'b0},
    {1'b0, 32'h8000_0000, 2'b10, 1'b1, 1'b1},
    {1'b0, 32'h8FFF_FFFF, 2'b10, 1'b1, 1'b1},
    {1'b0, 32'h9000_0000, 2'b00, 1'b0, 1'b0},
    {1'b1, 32'h1000_2000, 2'b01, 1'b0, 1'b0},
    {1'b1, 32'h2000_0000, 2'b00, 1'b1, 1'b0},
    {1'b1, 32'h8800_0000, 2'b10, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [31:0] txn_addr_i = '0;
  logic        txn_from_sec_i = 1'b0;
  logic [1:0]  win_hit_o, win_pref_o;
  logic        fwd_o, fwd_pref_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bmwd_top dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d; cfg_be_i = be;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_be_i = '0;
  endtask

  task automatic cfg_rd(string req, logic [7:0] a, logic [31:0] exp);
    cfg_addr_i = a;
    #1;
    check(req, cfg_rdata_o, exp);
  endtask

  task automatic dec(string req, logic sec, logic [31:0] a,
                     logic [1:0] eh, logic ef, logic ep);
    @(negedge clk_i);
    txn_addr_i = a; txn_from_sec_i = sec;
    @(negedge clk_i);
    check({req, " hit"},  32'(win_hit_o),  32'(eh));
    check({req, " fwd"},  32'(fwd_o),      32'(ef));
    check({req, " pref"}, 32'(fwd_pref_o), 32'(ep));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    txn_addr_i = 32'h1000_0000;
    repeat (2) @(negedge clk_i);
    check("R1 reset hit", 32'(win_hit_o), 0);
    check("R1 reset fwd", 32'(fwd_o), 0);
    rst_ni = 1'b1;
    cfg_rd("R1 base0", 8'h1C, 32'h0);
    cfg_rd("R1 limit0", 8'h20, 32'h0000_0FFF);
    cfg_rd("R1 limit1", 8'h28, 32'h0000_0FFF);
    cfg_rd("R1 ctl", 8'h3C, 32'h0);
    dec("R6 disabled pri", 1'b0, 32'h0, 2'b00, 1'b0, 1'b0);
    dec("R6 disabled sec", 1'b1, 32'h0, 2'b00, 1'b1, 1'b0);

    cfg_wr(8'h1C, 32'h1000_0000, 4'hF);
    cfg_wr(8'h20, 32'h1000_3000, 4'hF);
    cfg_wr(8'h24, 32'h8000_0000, 4'hF);
    cfg_wr(8'h28, 32'h8FFF_F000, 4'hF);
    cfg_wr(8'h3C, 32'h0200_0000, 4'h8);
    cfg_rd("R3 limit1", 8'h28, 32'h8FFF_FFFF);
    cfg_rd("R5 ctl", 8'h3C, 32'h0200_0000);
    check("R5 win_pref", 32'(win_pref_o), 32'h2);

    // R7 R8 R9 R10 table
    for (int i = 0; i < NVEC; i++)
      dec($sformatf("R7/R9 vec%0d", i), VECS[i][36], VECS[i][35:4],
          VECS[i][3:2], VECS[i][1], VECS[i][0]);

    // R2 low bits dropped on write
    cfg_wr(8'h24, 32'h8000_0ABC, 4'hF);
    cfg_rd("R2 base1 low", 8'h24, 32'h8000_0000);
    // R4 byte enables
    cfg_wr(8'h28, 32'hFFFF_FFFF, 4'h1);
    cfg_rd("R4 no stored byte", 8'h28, 32'h8FFF_FFFF);
    cfg_wr(8'h28, 32'h0012_0000, 4'h4);
    cfg_rd("R4 byte2", 8'h28, 32'h8F12_FFFF);
    // R11 unmapped
    cfg_wr(8'h30, 32'hFFFF_FFFF, 4'hF);
    cfg_rd("R11 unmapped", 8'h30, 32'h0);
    cfg_rd("R11 low addr bits", 8'h1F, 32'h1000_0000);
    // R5 control byte gating
    cfg_wr(8'h3C, 32'hFFFF_FFFF, 4'h7);
    cfg_rd("R5 ctl gated", 8'h3C, 32'h0200_0000);
    // R10 overlap priority
    cfg_wr(8'h1C, 32'h8000_0000, 4'hF);
    cfg_wr(8'h20, 32'h8000_0000, 4'hF);
    dec("R10 win0 first", 1'b0, 32'h8000_0800, 2'b11, 1'b1, 1'b0);
    cfg_wr(8'h3C, 32'hFF00_0000, 4'h8);
    cfg_rd("R5 ctl both", 8'h3C, 32'h0300_0000);
    dec("R10 win0 pref", 1'b0, 32'h8000_0800, 2'b11, 1'b1, 1'b1);
    cfg_wr(8'h3C, 32'h0200_0000, 4'h8);
    // R7 inverted window
    cfg_wr(8'h1C, 32'h0000_5000, 4'hF);
    cfg_wr(8'h20, 32'h0000_4000, 4'hF);
    dec("R7 inverted", 1'b0, 32'h0000_4800, 2'b00, 1'b0, 1'b0);
    // R6 enabled by limit alone, base 0
    cfg_wr(8'h1C, 32'h0, 4'hF);
    cfg_wr(8'h20, 32'h0000_1000, 4'hF);
    dec("R6 limit only", 1'b0, 32'h0000_0000, 2'b01, 1'b1, 1'b0);
    cfg_wr(8'h20, 32'h0, 4'hF);
    dec("R6 disabled again", 1'b0, 32'h0000_0000, 2'b00, 1'b0, 1'b0);
    dec("R9 sec miss", 1'b1, 32'h0000_0000, 2'b00, 1'b1, 1'b0);
    // R8 registered: output holds until the edge
    @(negedge clk_i);
    txn_addr_i = 32'h8000_0000; txn_from_sec_i = 1'b0;
    #1;
    check("R8 not yet", 32'(win_hit_o), 0);
    @(negedge clk_i);
    check("R8 after edge", 32'(win_hit_o), 32'h2);
    finish_run();
  end
endmodule